// File: doc/BRIEF.md
# Rotating-Mask 4-bit Substitution Unit

This block evaluates a 4-bit cipher substitution on data protected by first-order Boolean masking. The caller supplies the masked nibble and the mask that hides it. The block returns a masked result and the mask that hides that result. The plain nibble is never formed on any wire or register, because the result comes from a precomputed table indexed by the masked input and its mask.

In rotating mode the output mask needs no new randomness. It is the input mask incremented by one, modulo 16, so an evaluation costs 4 random bits. In general mode the caller supplies a third, independent output mask, for 8 random bits per evaluation. The same table serves both modes. In general mode a mask-difference term, built only from the two masks, is folded into the registered result.

Inputs are accepted with a valid/ready handshake. Results and the output mask come from one register stage together with a valid flag.

Top module: `rmask_sbox_unit`

## Requirements
- R1: While `rst` is high, `out_valid`, `y_masked`, `m_out` and `in_ready` are all 0 after the clock edge.
- R2: `in_ready` is 1 from the first clock edge on which `rst` is sampled low, and it stays 1 while `rst` remains low.
- R3: `out_valid` is 1 in exactly the cycle that follows a clock edge where `in_valid` and `in_ready` are both 1. Otherwise it is 0.
- R4: When `mode_gen` is 0 (rotating mode), the registered `m_out` equals the accepted `m_in` plus 1 modulo 16. An input mask of 15 gives an output mask of 0.
- R5: In rotating mode, `y_masked XOR m_out` equals S(`a_masked XOR m_in`), where S maps indices 0 to 15 to the hex values C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
- R6: When `mode_gen` is 1 (general mode), the registered `m_out` equals the accepted `m_out_ext`, and `y_masked XOR m_out` equals S(`a_masked XOR m_in`).
- R7: In rotating mode, `m_out_ext` has no effect on `y_masked` or `m_out`.
- R8: When no handshake completes at an edge, `y_masked` and `m_out` keep their values.
- R9: Every one of the 16 input mask values, including 0, gives a correct result in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operands are valid |
| in_ready | output | 1 | Unit can accept an operand |
| mode_gen | input | 1 | 0 = rotating output mask, 1 = external output mask |
| a_masked | input | 4 | Masked input nibble |
| m_in | input | 4 | Mask applied to the input nibble |
| m_out_ext | input | 4 | Output mask used in general mode |
| out_valid | output | 1 | Registered result is new this cycle |
| y_masked | output | 4 | Masked substitution result |
| m_out | output | 4 | Mask applied to `y_masked` |

## Verification
The bench builds the unit with its default nibble width of 4. That is the only width the substitution table defines, and it gives a 256-entry index space of masked input and input mask. With that width, every (masked input, mask) pair in rotating mode can be swept exhaustively, including the wrap of mask 15 to 0. A random sample of general-mode triples is also run alongside hand-worked vectors. Directed steps cover reset, the release of ready, holding the outputs with no handshake, and showing that the external mask has no effect in rotating mode.

// File: rtl/rms_pkg.sv
package rms_pkg;

  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NIB_N   = 1 << NIB_W;
  localparam int unsigned IDX_W   = 2 * NIB_W;
  localparam int unsigned TAB_N   = 1 << IDX_W;
  localparam int unsigned IMG_W   = TAB_N * NIB_W;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic {
    MODE_ROT = 1'b0,
    MODE_GEN = 1'b1
  } mask_mode_e;

  // Plain substitution, used only at elaboration to build the masked table
  // and by verification code.
  function automatic nib_t sbox_ref(input nib_t x);
    nib_t r;
    case (x)
      4'h0: r = 4'hC;  4'h1: r = 4'h5;  4'h2: r = 4'h6;  4'h3: r = 4'hB;
      4'h4: r = 4'h9;  4'h5: r = 4'h0;  4'h6: r = 4'hA;  4'h7: r = 4'hD;
      4'h8: r = 4'h3;  4'h9: r = 4'hE;  4'hA: r = 4'hF;  4'hB: r = 4'h8;
      4'hC: r = 4'h4;  4'hD: r = 4'h7;  4'hE: r = 4'h1;  default: r = 4'h2;
    endcase
    return r;
  endfunction

  // Successor of a mask in the rotation order.
  function automatic nib_t mask_next(input nib_t m);
    return nib_t'(m + nib_t'(1));
  endfunction

  // Table image: entry {a, mi} holds S(a ^ mi) ^ next(mi).
  function automatic logic [IMG_W-1:0] build_image();
    logic [IMG_W-1:0] img;
    img = '0;
    for (int a = 0; a < NIB_N; a++) begin
      for (int m = 0; m < NIB_N; m++) begin
        img[((a * NIB_N) + m) * NIB_W +: NIB_W] =
          sbox_ref(nib_t'(a) ^ nib_t'(m)) ^ mask_next(nib_t'(m));
      end
    end
    return img;
  endfunction

endpackage

// File: rtl/rms_mask_path.sv
module rms_mask_path
  import rms_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic         mode_gen,
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] m_out_ext,
  output logic [W-1:0] m_out_sel,
  output logic [W-1:0] m_delta
);
  logic [W-1:0] m_rot;

  assign m_rot = W'(m_in + W'(1));

  always_comb begin
    if (mask_mode_e'(mode_gen) == MODE_GEN) begin
      m_out_sel = m_out_ext;
    end else begin
      m_out_sel = m_rot;
    end
  end

  // Difference between the mask baked into the table and the requested one.
  // Built from masks only, so it carries no data.
  assign m_delta = m_rot ^ m_out_sel;

endmodule

// File: rtl/rms_table.sv
module rms_table
  import rms_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic [W-1:0] a_masked,
  input  logic [W-1:0] m_in,
  output logic [W-1:0] t_out
);
  localparam int unsigned IW    = 2 * W;
  localparam int unsigned DEPTH = 1 << IW;
  localparam logic [IMG_W-1:0] IMAGE = build_image();

  logic [W-1:0] rom [DEPTH];
  logic [IW-1:0] idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = IMAGE[g*W +: W];
  end

  // Index is the concatenation, never the XOR, of data and mask.
  assign idx   = {a_masked, m_in};
  assign t_out = rom[idx];

endmodule

// File: rtl/rmask_sbox_unit.sv
module rmask_sbox_unit
  import rms_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         mode_gen,
  input  logic [W-1:0] a_masked,
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] m_out_ext,
  output logic         out_valid,
  output logic [W-1:0] y_masked,
  output logic [W-1:0] m_out
);
  logic [W-1:0] t_val;
  logic [W-1:0] m_sel;
  logic [W-1:0] m_dlt;
  logic         accept;
  logic         rdy_q;
  logic         vld_q;
  logic [W-1:0] y_q;
  logic [W-1:0] mo_q;

  rms_table #(.W(W)) u_table (
    .a_masked (a_masked),
    .m_in     (m_in),
    .t_out    (t_val)
  );

  rms_mask_path #(.W(W)) u_mask (
    .mode_gen  (mode_gen),
    .m_in      (m_in),
    .m_out_ext (m_out_ext),
    .m_out_sel (m_sel),
    .m_delta   (m_dlt)
  );

  assign accept = in_valid && rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
      y_q   <= '0;
      mo_q  <= '0;
    end else begin
      rdy_q <= 1'b1;
      vld_q <= accept;
      if (accept) begin
        y_q  <= t_val ^ m_dlt;
        mo_q <= m_sel;
      end
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = vld_q;
  assign y_masked  = y_q;
  assign m_out     = mo_q;

endmodule

// File: rtl/rmask_sbox_chk.sv
module rmask_sbox_chk
  import rms_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         mode_gen,
  input logic [W-1:0] a_masked,
  input logic [W-1:0] m_in,
  input logic [W-1:0] m_out_ext,
  input logic         out_valid,
  input logic [W-1:0] y_masked,
  input logic [W-1:0] m_out
);
  logic hs;
  assign hs = in_valid && in_ready;

  a_r2_ready_up: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> in_ready);

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(hs)));

  a_r4_rotate_mask: assert property (@(posedge clk) disable iff (rst)
    (hs && !mode_gen) |=> (m_out == W'($past(m_in) + W'(1))));

  a_r5_rotate_value: assert property (@(posedge clk) disable iff (rst)
    (hs && !mode_gen) |=> ((y_masked ^ m_out) == sbox_ref($past(a_masked ^ m_in))));

  a_r6_general_mask: assert property (@(posedge clk) disable iff (rst)
    (hs && mode_gen) |=> (m_out == $past(m_out_ext)));

  a_r6_general_value: assert property (@(posedge clk) disable iff (rst)
    (hs && mode_gen) |=> ((y_masked ^ m_out) == sbox_ref($past(a_masked ^ m_in))));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !hs |=> ($stable(y_masked) && $stable(m_out)));

endmodule

bind rmask_sbox_unit rmask_sbox_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mode_gen  (mode_gen),
  .a_masked  (a_masked),
  .m_in      (m_in),
  .m_out_ext (m_out_ext),
  .out_valid (out_valid),
  .y_masked  (y_masked),
  .m_out     (m_out)
);

// File: tb/rmask_sbox_unit_test.sv
`timescale 1ns/1ps
module rmask_sbox_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       mode_gen = 1'b0;
  logic [3:0] a_masked = '0;
  logic [3:0] m_in = '0;
  logic [3:0] m_out_ext = '0;
  logic       out_valid;
  logic [3:0] y_masked;
  logic [3:0] m_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rmask_sbox_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode_gen(mode_gen), .a_masked(a_masked), .m_in(m_in),
    .m_out_ext(m_out_ext), .out_valid(out_valid), .y_masked(y_masked),
    .m_out(m_out)
  );

  // Substitution from the requirement text.
  function automatic logic [3:0] s_of(input logic [3:0] x);
    logic [63:0] t;
    t = 64'h21748FE3DA09B65C;
    return t[x*4 +: 4];
  endfunction

  // Vector fields: mode, a, mi, mo_ext, expected y, expected mo
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'h0, 4'h0, 4'h0, 4'hD, 4'h1},
    {1'b0, 4'h5, 4'hF, 4'h0, 4'hF, 4'h0},
    {1'b0, 4'h3, 4'h7, 4'h0, 4'h1, 4'h8},
    {1'b1, 4'h9, 4'h2, 4'h6, 4'hE, 4'h6},
    {1'b1, 4'hF, 4'hF, 4'h0, 4'hC, 4'h0},
    {1'b1, 4'h1, 4'h8, 4'hF, 4'h1, 4'hF},
    {1'b0, 4'hE, 4'h4, 4'h9, 4'hA, 4'h5},
    {1'b1, 4'h6, 4'h0, 4'h0, 4'hA, 4'h0}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operand for one edge, then sample half a cycle after the output edge.
  task automatic run_op(input logic md, input logic [3:0] a, input logic [3:0] mi,
                        input logic [3:0] mo);
    @(negedge clk);
    mode_gen = md; a_masked = a; m_in = mi; m_out_ext = mo; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] hy, hm, r_a, r_mi, r_mo;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {3'b0, out_valid}, 4'h0);
    chk("R1 y_masked", y_masked, 4'h0);
    chk("R1 m_out", m_out, 4'h0);
    chk("R1 in_ready", {3'b0, in_ready}, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 in_ready", {3'b0, in_ready}, 4'h1);

    // Table of worked vectors (R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][20], VEC[i][19:16], VEC[i][15:12], VEC[i][11:8]);
      chk("R3 out_valid", {3'b0, out_valid}, 4'h1);
      chk(VEC[i][20] ? "R6 vector y" : "R5 vector y", y_masked, VEC[i][7:4]);
      chk(VEC[i][20] ? "R6 vector mo" : "R4 vector mo", m_out, VEC[i][3:0]);
    end

    // R5 R9: every (a, mi) pair in rotating mode
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 16; m++) begin
        run_op(1'b0, 4'(a), 4'(m), 4'(a + 3));
        chk("R4 R9 rotate mo", m_out, 4'(m + 1));
        chk("R5 R9 rotate unmask", y_masked ^ m_out, s_of(4'(a) ^ 4'(m)));
      end
    end

    // R6 R9: random general triples
    for (int k = 0; k < 64; k++) begin
      r_a = 4'($urandom); r_mi = 4'(k); r_mo = 4'($urandom);
      run_op(1'b1, r_a, r_mi, r_mo);
      chk("R6 general mo", m_out, r_mo);
      chk("R6 R9 general unmask", y_masked ^ m_out, s_of(r_a ^ r_mi));
    end

    // R3: no handshake -> out_valid low
    @(negedge clk);
    chk("R3 idle out_valid", {3'b0, out_valid}, 4'h0);

    // R7: external mask ignored in rotating mode
    run_op(1'b0, 4'hB, 4'hF, 4'h3);
    hy = y_masked; hm = m_out;
    run_op(1'b0, 4'hB, 4'hF, 4'hC);
    chk("R7 ext ignored y", y_masked, hy);
    chk("R7 ext ignored mo", m_out, hm);
    chk("R4 wrap 15->0", m_out, 4'h0);

    // R8: hold without handshake while inputs move
    @(negedge clk);
    mode_gen = 1'b1; a_masked = 4'h7; m_in = 4'h2; m_out_ext = 4'h9;
    repeat (3) @(negedge clk);
    chk("R8 hold y", y_masked, hy);
    chk("R8 hold mo", m_out, hm);
    chk("R8 out_valid low", {3'b0, out_valid}, 4'h0);

    // R1: reset again clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R1 re-reset y", y_masked, 4'h0);
    chk("R1 re-reset ready", {3'b0, in_ready}, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 ready again", {3'b0, in_ready}, 4'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule